// File: doc/BRIEF.md
# One-Time-Programmable Memory Mode Controller

This block models, in synthesizable form, the control side of a byte-wide one-time-programmable memory. It takes a chip-select (`ce_ni`), an output-gate (`oe_ni`), a flag saying the programming supply is raised, and a flag saying the identify line is at high voltage. From these it decides whether the part reads, floats its outputs, programs a byte, verifies a byte, inhibits programming, or returns its identifier bytes.

The storage is a small internal register file. Every cell comes out of reset as all ones. A program operation can only clear bits: the new cell value is the old value ANDed with the data presented. A write is taken on a rising clock edge while program mode is active. Only one write is taken per chip-select low pulse, so holding the select low for several clocks has the same effect as one short pulse.

When the select is high, the outputs are released regardless of the output gate, and a standby flag is raised. With the identify line at high voltage, a normal supply, and every address bit above bit 0 low, bit 0 selects between the manufacturer byte and the device byte. If any of those upper address bits is high, the normal array contents are read instead.

Top module: `otp_mode_ctrl`

## Requirements
- R1: After reset every cell reads 8'hFF; a program operation stores the old cell value ANDed with `data_i`, so no bit ever returns from 0 to 1.
- R2: `data_oe_o` is 1 only with `ce_ni`=0 and `oe_ni`=0; at normal supply and no identify, `data_o` then equals the cell at `addr_i`.
- R3: With `ce_ni`=0, `oe_ni`=1 and `vpp_hi_i`=0, `data_oe_o` is 0 and clock edges write nothing.
- R4: With `ce_ni`=1 and `vpp_hi_i`=0, `data_oe_o` is 0 for either level of `oe_ni`.
- R5: With `vpp_hi_i`=1 and `ce_ni`=1, for either level of `oe_ni`, `data_oe_o` is 0 and no cell changes.
- R6: With `vpp_hi_i`=1, `ce_ni`=0 and `oe_ni`=0, the stored byte at `addr_i` is driven with `data_oe_o`=1, whatever the level of `a9_vh_i`.
- R7: With `vpp_hi_i`=1, `ce_ni`=0 and `oe_ni`=1, the first rising clock edge writes `data_i` into `addr_i`. Later edges in the same `ce_ni` low pulse write nothing. A new write needs `ce_ni` to be seen high at a rising edge first.
- R8: With `a9_vh_i`=1, `vpp_hi_i`=0, `ce_ni`=`oe_ni`=0 and `addr_i[ADDR_W-1:1]`=0, `data_o` is 8'hC2 when `addr_i[0]`=0 and 8'hC0 when `addr_i[0]`=1, with `data_oe_o`=1.
- R9: With `a9_vh_i`=1 and any of `addr_i[ADDR_W-1:1]` nonzero, a read returns the array contents at `addr_i`.
- R10: `standby_o` equals `ce_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are taken on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; sets all cells to ones |
| addr_i | input | ADDR_W | Byte address |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| vpp_hi_i | input | 1 | Programming supply raised |
| a9_vh_i | input | 1 | Identify line at high voltage |
| data_i | input | DATA_W | Byte to program |
| data_o | output | DATA_W | Read, verify or identifier byte; 0 when not driven |
| data_oe_o | output | 1 | Data bus drive enable |
| standby_o | output | 1 | Standby indicator |

## Verification
The bench builds the block with ADDR_W=5, which gives 32 cells. This small size makes it cheap to sweep every address in reset, read, verify and two overlapping program passes, and to check the expected AND result for each cell. It also lets the bench try every address with the identify flag raised, so the two identifier bytes and all 30 invalid identify addresses are covered. Every combination of select, gate and supply is applied, including long select-low pulses with changing data, to show that only one write is taken per pulse.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUT_DIS,
    M_READ,
    M_IDENT,
    M_PROGRAM,
    M_VERIFY,
    M_INHIBIT
  } otp_mode_e;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode #(
  parameter int ADDR_W = 5
) (
  input  logic                   ce_ni,
  input  logic                   oe_ni,
  input  logic                   vpp_hi_i,
  input  logic                   a9_vh_i,
  input  logic [ADDR_W-2:0]      upper_addr_i,
  output otp_pkg::otp_mode_e     mode_o
);
  import otp_pkg::*;

  always_comb begin
    if (vpp_hi_i) begin
      if (ce_ni)      mode_o = M_INHIBIT;
      else if (oe_ni) mode_o = M_PROGRAM;
      else            mode_o = M_VERIFY;
    end else begin
      if (ce_ni)      mode_o = M_STANDBY;
      else if (oe_ni) mode_o = M_OUT_DIS;
      else if (a9_vh_i && (upper_addr_i == '0)) mode_o = M_IDENT;
      else            mode_o = M_READ;
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cells_q [DEPTH];
  logic              armed_q;
  logic              wr_fire;

  assign wr_fire = prog_i && armed_q;
  assign rdata_o = cells_q[addr_i];

  // one write per select-low pulse; re-armed once select is seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b1;
    else if (ce_ni)    armed_q <= 1'b1;
    else if (wr_fire)  armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cells_q[i] <= '1;
    end else if (wr_fire) begin
      cells_q[addr_i] <= cells_q[addr_i] & wdata_i;
    end
  end

  assert_single_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom #(
  parameter int             DATA_W   = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hC2,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hC0
) (
  input  logic              sel_i,
  output logic [DATA_W-1:0] id_o
);
  assign id_o = sel_i ? DEV_CODE : MFR_CODE;
endmodule

// File: rtl/otp_mode_ctrl.sv
module otp_mode_ctrl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hC2,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hC0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              a9_vh_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              standby_o
);
  import otp_pkg::*;

  otp_mode_e         mode;
  logic [DATA_W-1:0] cell_rd;
  logic [DATA_W-1:0] id_byte;

  otp_mode_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .vpp_hi_i    (vpp_hi_i),
    .a9_vh_i     (a9_vh_i),
    .upper_addr_i(addr_i[ADDR_W-1:1]),
    .mode_o      (mode)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .prog_i (mode == M_PROGRAM),
    .addr_i (addr_i),
    .wdata_i(data_i),
    .rdata_o(cell_rd)
  );

  otp_id_rom #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .sel_i(addr_i[0]),
    .id_o (id_byte)
  );

  always_comb begin
    data_oe_o = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_IDENT);
    if (!data_oe_o)          data_o = '0;
    else if (mode == M_IDENT) data_o = id_byte;
    else                     data_o = cell_rd;
  end

  assign standby_o = ce_ni;

  assert_drive_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni));
  assert_disable_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni) |-> !data_oe_o);
  assert_standby_float_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!data_oe_o && standby_o));
  assert_bits_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_VERIFY && $past(mode == M_VERIFY) && $stable(addr_i))
      |-> ((data_o & ~$past(data_o)) == '0));
  assert_ident_mfr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && a9_vh_i && !ce_ni && !oe_ni && addr_i == '0) |-> (data_o == MFR_CODE));
endmodule

// File: tb/otp_mode_ctrl_tb.sv
`timescale 1ns/1ps
module otp_mode_ctrl_tb;
  localparam int AW = 5;
  localparam int N  = 1 << AW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1, oe_n = 1, vpp = 0, a9 = 0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          doe, stby;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] model [N];

  always #2.5 clk = ~clk;

  otp_mode_ctrl #(.ADDR_W(AW), .DATA_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .vpp_hi_i(vpp), .a9_vh_i(a9), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .standby_o(stby)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; a9 = 0; vpp = 1; oe_n = 1; ce_n = 0;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    model[a] = model[a] & d;
  endtask

  task automatic look(string req, logic v, logic a9v, logic [AW-1:0] a, logic [7:0] exp);
    @(negedge clk); vpp = v; a9 = a9v; addr = a; ce_n = 0; oe_n = 0;
    #1;
    chk(req, {dout, doe}, {exp, 1'b1});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R4 reset float", {31'd0, doe}, 0);
    chk("R10 reset standby", {31'd0, stby}, 1);
    rst_n = 1;

    // R1: erased array reads all ones
    for (int a = 0; a < N; a++) look("R1 erased", 0, 0, AW'(a), 8'hFF);

    // R7: first pass programming, checked by verify (R6) and read (R2)
    for (int a = 0; a < N; a++) prog(AW'(a), 8'((a * 37 + 5) & 255));
    for (int a = 0; a < N; a++) look("R6 verify", 1, a[0], AW'(a), model[a]);
    for (int a = 0; a < N; a++) look("R2 read", 0, 0, AW'(a), model[a]);

    // R1: second pass can only clear further bits
    for (int a = 0; a < N; a++) prog(AW'(a), 8'(a ^ 8'hB6));
    for (int a = 0; a < N; a++) look("R1 and-only", 1, 0, AW'(a), model[a]);

    // R7: held select with changing data takes only the first edge
    @(negedge clk); addr = 5; din = 8'h7E; a9 = 0; vpp = 1; oe_n = 1; ce_n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); din = 8'h00;
    end
    ce_n = 1;
    model[5] = model[5] & 8'h7E;
    look("R7 one write per pulse", 1, 0, 5, model[5]);

    // R3: output disable floats and writes nothing
    @(negedge clk); vpp = 0; a9 = 0; addr = 9; din = 8'h00; ce_n = 0; oe_n = 1;
    #1; chk("R3 disable float", {31'd0, doe}, 0);
    chk("R10 select low", {31'd0, stby}, 0);
    repeat (3) @(negedge clk);
    ce_n = 1;
    look("R3 no write", 0, 0, 9, model[9]);

    // R4: standby floats for both gate levels
    for (int g = 0; g < 2; g++) begin
      @(negedge clk); vpp = 0; ce_n = 1; oe_n = g[0];
      #1; chk("R4 standby float", {30'd0, doe, stby}, {30'd0, 1'b0, 1'b1});
    end

    // R5: inhibit under raised supply
    for (int g = 0; g < 2; g++) begin
      @(negedge clk); vpp = 1; ce_n = 1; oe_n = g[0]; addr = 12; din = 8'h00;
      #1; chk("R5 inhibit float", {31'd0, doe}, 0);
      repeat (3) @(negedge clk);
    end
    look("R5 inhibit no write", 1, 0, 12, model[12]);

    // R8: identifier bytes
    look("R8 manufacturer", 0, 1, 0, 8'hC2);
    look("R8 device", 0, 1, 1, 8'hC0);

    // R9: identify with upper address bits set reads the array
    for (int a = 2; a < N; a++) look("R9 invalid ident", 0, 1, AW'(a), model[a]);

    @(negedge clk); ce_n = 1; oe_n = 1; vpp = 0; a9 = 0;
    done = 1;
    finish_run();
  end
endmodule